// File: doc/BRIEF.md
# Dual-Clause MDIO Management Master

This block drives a two-wire station management bus towards one or more PHYs. A small register-style port carries three write targets: a configuration word (MDC divider, framing mode select and preamble enable), a write-data word, and a command word (2-bit opcode, 5-bit port address, 5-bit register or device address). A command write while idle launches one management frame. For writes and address frames the 16-bit payload is taken from the write-data word. For reads, the block releases MDIO at the turnaround, shifts in 16 data bits, and reports them with a valid flag.

One mode bit chooses between the two framing variants, and the opcode field is decoded differently in each. A register read in the extended-address variant takes two commands: an address frame that carries the register number, then a read frame to the same port and device. The block itself keeps no address state between frames.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc and mdio_oe are low, mdio_o is high, wr_pending, rd_pending and rd_valid are low, and rd_data is zero.
- R2: While a frame is in progress, each high and each low phase of mdc lasts cfg_div+1 system clocks, using the cfg_div value latched at the last accepted configuration write. mdc stays low while no frame is in progress.
- R3: When the preamble bit is set, 32 ones with mdio_oe high come before the frame, for 64 mdc periods in total. When it is clear, the frame starts at once and lasts 32 mdc periods.
- R4: With the mode bit clear, the frame is start 01, then opcode bits 01 for a write (cmd_op bit0 = 0) or 10 for a read (cmd_op bit0 = 1). cmd_op bit1 is ignored. Then come the 5 port bits, the 5 register bits, turnaround 10 on writes and 16 data bits. Every field is sent MSB first.
- R5: With the mode bit set, the frame starts with 00, and cmd_op is sent as-is as the two opcode bits: 0 address, 1 write, 2 read with post-increment, 3 read. cmd_reg carries the device address, and address and write frames carry the write-data word.
- R6: mdio_o changes only in the system clock where mdc falls. mdio_i is sampled where mdc rises.
- R7: wr_pending rises one clock after a write or address command is accepted and clears after the falling mdc edge that ends the last bit. At most one of wr_pending and rd_pending is set at a time.
- R8: On a read, rd_pending rises and rd_valid clears one clock after the command. mdio_oe is low from the first turnaround bit to the end of the frame. At completion rd_data holds the 16 sampled bits, MSB first, and rd_valid is set.
- R9: If the PHY leaves the second turnaround bit high during a read, rd_valid stays low after completion.
- R10: Command and configuration writes that arrive while a frame is in progress have no effect: the frame, its timing and the flags are unchanged, and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | DIV_W | MDC half-period minus one, in system clocks |
| cfg_clause45 | input | 1 | 1 selects extended-address framing, 0 the basic framing |
| cfg_preamble | input | 1 | 1 sends 32 ones before each frame |
| wdat_we | input | 1 | Write-data strobe |
| wdat | input | 16 | Payload for write and address frames |
| cmd_we | input | 1 | Command strobe; starts a frame when idle |
| cmd_op | input | 2 | Opcode, decoded by mode |
| cmd_phy | input | 5 | Port address |
| cmd_reg | input | 5 | Register address, or device address in extended mode |
| mdio_i | input | 1 | MDIO input from the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| wr_pending | output | 1 | Write or address frame in progress |
| rd_pending | output | 1 | Read frame in progress |
| rd_valid | output | 1 | Last read completed with a good turnaround |
| rd_data | output | 16 | Data of the last read |

## Verification
The bench builds the block with DIV_W = 2, which makes the whole divider range 0 to 3 reachable. At that width the bench can sweep every divider value against both framing modes, all four opcodes and both preamble settings. A PHY model in the bench answers reads with a known word and can spoil the turnaround. Each captured frame is compared bit for bit with one assembled arithmetically from the command fields, and the phase lengths of mdc are measured against cfg_div+1.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = 32;
  localparam int TA_POS     = 14;  // first turnaround bit within a frame
  localparam int DATA_POS   = 16;  // first data bit within a frame

  // start code: basic framing 01, extended framing 00
  function automatic logic [1:0] start_code(input logic ext);
    return ext ? 2'b00 : 2'b01;
  endfunction

  // opcode bits on the wire
  function automatic logic [1:0] op_code(input logic ext, input logic [1:0] op);
    logic [1:0] r;
    if (!ext) r = op[0] ? 2'b10 : 2'b01;
    else begin
      case (op)
        2'd0:    r = 2'b00;  // address
        2'd1:    r = 2'b01;  // write
        2'd2:    r = 2'b10;  // read, post-increment
        default: r = 2'b11;  // read
      endcase
    end
    return r;
  endfunction

  function automatic logic op_is_read(input logic ext, input logic [1:0] op);
    return ext ? op[1] : op[0];
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic ext, input logic [1:0] op,
      input logic [ADDR_W-1:0] phy, input logic [ADDR_W-1:0] regad,
      input logic [DATA_W-1:0] data);
    logic rd;
    rd = op_is_read(ext, op);
    return {start_code(ext), op_code(ext, op), phy, regad,
            rd ? 2'b11 : 2'b10, rd ? {DATA_W{1'b1}} : data};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             tick_rise,
  output logic             tick_fall
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = run && (cnt == div);
  assign tick_rise = wrap && !mdc;
  assign tick_fall = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  assert_mdc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != div) |=> $stable(mdc));
endmodule

// File: rtl/mdio_framer.sv
module mdio_framer
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext,
  input  logic              pre_en,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_rise,
  input  logic              tick_fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              ta_ok
);
  localparam int SR_W  = PRE_LEN + FRAME_BITS;
  localparam int POS_W = $clog2(SR_W);

  logic [SR_W-1:0]  tx_sr;
  logic [POS_W-1:0] pos, last_q, off_q, fidx;
  logic             rd_q, in_frame, rx_phase;
  logic [FRAME_BITS-1:0] frame_w;

  assign frame_w  = build_frame(ext, op, phy, regad, wdata);
  assign fidx     = pos - off_q;
  assign in_frame = pos >= off_q;
  assign rx_phase = rd_q && in_frame && (fidx >= POS_W'(TA_POS));
  assign done     = busy && tick_fall && (pos == last_q);
  assign mdio_o   = busy ? tx_sr[SR_W-1] : 1'b1;
  assign mdio_oe  = busy && !rx_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tx_sr   <= '0;
      pos     <= '0;
      last_q  <= '0;
      off_q   <= '0;
      rd_q    <= 1'b0;
      rx_data <= '0;
      ta_ok   <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      pos     <= '0;
      rd_q    <= op_is_read(ext, op);
      rx_data <= '0;
      ta_ok   <= 1'b0;
      if (pre_en) begin
        tx_sr  <= {{PRE_LEN{1'b1}}, frame_w};
        last_q <= POS_W'(SR_W - 1);
        off_q  <= POS_W'(PRE_LEN);
      end else begin
        tx_sr  <= {frame_w, {PRE_LEN{1'b0}}};
        last_q <= POS_W'(FRAME_BITS - 1);
        off_q  <= '0;
      end
    end else if (busy) begin
      if (tick_rise && rd_q && in_frame) begin
        if (fidx == POS_W'(TA_POS + 1)) ta_ok <= !mdio_i;
        if (fidx >= POS_W'(DATA_POS)) rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      end
      if (tick_fall) begin
        if (pos == last_q) busy <= 1'b0;
        else begin
          pos   <= pos + 1'b1;
          tx_sr <= {tx_sr[SR_W-2:0], 1'b0};
        end
      end
    end
  end

  assert_tx_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_fall) |=> $stable(mdio_o));
  assert_release_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |-> rd_q);
  assert_oe_off_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_clause45,
  input  logic              cfg_preamble,
  input  logic              wdat_we,
  input  logic [15:0]       wdat,
  input  logic              cmd_we,
  input  logic [1:0]        cmd_op,
  input  logic [4:0]        cmd_phy,
  input  logic [4:0]        cmd_reg,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              wr_pending,
  output logic              rd_pending,
  output logic              rd_valid,
  output logic [15:0]       rd_data
);
  logic [DIV_W-1:0]  div_q;
  logic              ext_q, pre_q;
  logic [DATA_W-1:0] wdat_q;
  logic              busy, done, start, tick_rise, tick_fall, ta_ok;
  logic [DATA_W-1:0] rx_data;

  assign start = cmd_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ext_q  <= 1'b0;
      pre_q  <= 1'b0;
      wdat_q <= '0;
    end else begin
      if (cfg_we && !busy) begin
        div_q <= cfg_div;
        ext_q <= cfg_clause45;
        pre_q <= cfg_preamble;
      end
      if (wdat_we) wdat_q <= wdat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pending <= 1'b0;
      rd_pending <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else if (start) begin
      if (op_is_read(ext_q, cmd_op)) begin
        rd_pending <= 1'b1;
        rd_valid   <= 1'b0;
      end else begin
        wr_pending <= 1'b1;
      end
    end else if (done) begin
      wr_pending <= 1'b0;
      rd_pending <= 1'b0;
      if (rd_pending) begin
        rd_data  <= rx_data;
        rd_valid <= ta_ok;
      end
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
    .mdc(mdc), .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  mdio_framer #(.PRE_LEN(32)) u_frm (
    .clk(clk), .rst_n(rst_n), .start(start), .ext(ext_q), .pre_en(pre_q),
    .op(cmd_op), .phy(cmd_phy), .regad(cmd_reg), .wdata(wdat_q),
    .tick_rise(tick_rise), .tick_fall(tick_fall), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rx_data(rx_data), .ta_ok(ta_ok)
  );

  assert_one_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pending && rd_pending));
  assert_pending_tracks_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pending || rd_pending) == busy);
  assert_valid_at_read_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $fell(rd_pending));
  assert_cfg_held_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we) |=> $stable(div_q));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int DW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_c45 = 1'b0, cfg_pre = 1'b0;
  logic [DW-1:0] cfg_div = '0;
  logic          wdat_we = 1'b0;
  logic [15:0]   wdat = '0;
  logic          cmd_we = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [4:0]    cmd_phy = '0, cmd_reg = '0;
  logic          mdio_i = 1'b1;
  logic          mdc, mdio_o, mdio_oe, wr_pending, rd_pending, rd_valid;
  logic [15:0]   rd_data;

  mdio_master #(.DIV_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_clause45(cfg_c45), .cfg_preamble(cfg_pre), .wdat_we(wdat_we),
    .wdat(wdat), .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_phy(cmd_phy),
    .cmd_reg(cmd_reg), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .wr_pending(wr_pending), .rd_pending(rd_pending),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // bus monitor and PHY model, all in one process
  logic        mon_clr = 1'b0;
  int          cur_off = 0;
  logic [17:0] resp = '1;
  int          rise_cnt = 0, hi_run = 0, hi_min = 1000, hi_max = 0, edge_bad = 0;
  logic        cap_o [64];
  logic        cap_oe[64];
  logic        p_mdc = 1'b0, p_o = 1'b1, p_oe = 1'b0;

  always @(posedge clk) begin
    if (mon_clr) begin
      rise_cnt = 0; hi_run = 0; hi_min = 1000; hi_max = 0; edge_bad = 0;
      mdio_i <= 1'b1;
    end else begin
      if (!p_mdc && mdc) begin
        if (rise_cnt < 64) begin
          cap_o[rise_cnt]  = mdio_o;
          cap_oe[rise_cnt] = mdio_oe;
        end
        rise_cnt++;
        hi_run = 1;
        begin
          int fi;
          fi = rise_cnt - cur_off;
          mdio_i <= (fi >= 14 && fi <= 31) ? resp[31-fi] : 1'b1;
        end
      end else if (p_mdc && mdc) hi_run++;
      if (p_mdc && !mdc) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
      end
      if (p_oe && mdio_oe && (mdio_o != p_o) && !(p_mdc && !mdc)) edge_bad++;
    end
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
  end

  task automatic run_txn(input bit c45, input bit [1:0] op, input bit [4:0] phy,
                         input bit [4:0] rg, input bit [15:0] wd, input bit pre,
                         input int div, input bit [15:0] rdat, input bit ta_bad,
                         input bit poke);
    bit is_rd;
    int nb, hdr_len, saved;
    bit [31:0] exp_f;
    string fr;
    is_rd = c45 ? op[1] : op[0];
    nb    = pre ? 64 : 32;
    fr    = c45 ? "R5" : "R4";
    exp_f = {c45 ? 2'b00 : 2'b01, c45 ? op : (op[0] ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
    @(negedge clk);
    cfg_div = DW'(div); cfg_c45 = c45; cfg_pre = pre; cfg_we = 1'b1;
    wdat = wd; wdat_we = 1'b1; mon_clr = 1'b1;
    cur_off = pre ? 32 : 0;
    resp = {1'b1, ta_bad, rdat};
    @(negedge clk);
    cfg_we = 1'b0; wdat_we = 1'b0; mon_clr = 1'b0;
    cmd_op = op; cmd_phy = phy; cmd_reg = rg; cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(wr_pending == !is_rd && rd_pending == is_rd, is_rd ? "R8" : "R7",
        "pending after start", {wr_pending, rd_pending}, {!is_rd, is_rd});
    if (is_rd) chk(rd_valid == 1'b0, "R8", "valid cleared at read start", rd_valid, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_op = ~op; cmd_we = 1'b1; cfg_we = 1'b1;
      cfg_div = DW'(div ^ 1); cfg_pre = ~pre; cfg_c45 = ~c45;
      @(negedge clk);
      cmd_we = 1'b0; cfg_we = 1'b0;
    end
    for (int i = 0; i < 3000 && (wr_pending || rd_pending); i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(rise_cnt == nb, "R3", "mdc periods per frame", rise_cnt, nb);
    if (pre) begin
      int ones;
      ones = 0;
      for (int k = 0; k < 32; k++) if (cap_o[k] && cap_oe[k]) ones++;
      chk(ones == 32, "R3", "preamble ones driven", ones, 32);
    end
    hdr_len = is_rd ? 14 : 32;
    begin
      bit [31:0] got;
      int oe_bad;
      got = '0; oe_bad = 0;
      for (int k = 0; k < 32; k++) begin
        if (k < hdr_len) begin
          got[31-k] = cap_o[cur_off+k];
          if (!cap_oe[cur_off+k]) oe_bad++;
        end
      end
      chk(got[31-:14] == exp_f[31-:14], fr, "frame header", got[31-:14], exp_f[31-:14]);
      if (!is_rd) chk(got == exp_f, fr, "full write frame", got, exp_f);
      chk(oe_bad == 0, fr, "driven bits with oe high", oe_bad, 0);
    end
    if (is_rd) begin
      int oe_lo;
      oe_lo = 0;
      for (int k = 14; k < 32; k++) if (!cap_oe[cur_off+k]) oe_lo++;
      chk(oe_lo == 18, "R8", "released bits", oe_lo, 18);
      chk(rd_data == rdat, "R8", "read data", rd_data, rdat);
      if (ta_bad) chk(rd_valid == 1'b0, "R9", "valid with bad turnaround", rd_valid, 0);
      else        chk(rd_valid == 1'b1, "R8", "valid after read", rd_valid, 1);
    end
    chk(hi_min == div + 1 && hi_max == div + 1, "R2", "mdc high phase",
        {hi_min, hi_max}, {div + 1, div + 1});
    chk(mdc == 1'b0 && !wr_pending && !rd_pending, "R2", "idle after frame",
        {mdc, wr_pending, rd_pending}, 0);
    chk(edge_bad == 0, "R6", "mdio_o moves off falling mdc", edge_bad, 0);
    if (poke) begin
      saved = rise_cnt;
      repeat (40) @(negedge clk);
      chk(!wr_pending && !rd_pending && !mdc && rise_cnt == saved, "R10",
          "no frame from writes while busy", rise_cnt, saved);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0 && mdio_o == 1 && !wr_pending && !rd_pending &&
        !rd_valid && rd_data == 0, "R1", "reset outputs",
        {mdc, mdio_oe, mdio_o, wr_pending, rd_pending, rd_valid, rd_data},
        {6'b001000, 16'h0});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 4; o++)
        for (int p = 0; p < 2; p++)
          for (int d = 0; d < 4; d++)
            run_txn(c[0], o[1:0], 5'((o * 7 + d * 3 + c * 11 + p) & 31),
                    5'((o * 5 + d + c * 13 + p * 17) & 31),
                    16'hA5C3 ^ 16'((o << 12) | (d << 8) | (p << 4) | c),
                    p[0], d, 16'h3C5A ^ 16'((d << 4) | o), 1'b0, 1'b0);
    // spoiled turnaround in both modes
    run_txn(1'b0, 2'd1, 5'd3, 5'd2, 16'h0, 1'b0, 1, 16'hBEEF, 1'b1, 1'b0);
    run_txn(1'b1, 2'd3, 5'd9, 5'd1, 16'h0, 1'b1, 0, 16'h1234, 1'b1, 1'b0);
    // two-step extended read: address then read
    run_txn(1'b1, 2'd0, 5'd4, 5'd30, 16'h8001, 1'b1, 2, 16'h0, 1'b0, 1'b0);
    run_txn(1'b1, 2'd3, 5'd4, 5'd30, 16'h0, 1'b1, 2, 16'hC0DE, 1'b0, 1'b0);
    // writes during a frame are ignored
    run_txn(1'b0, 2'd0, 5'd17, 5'd6, 16'h5AA5, 1'b0, 1, 16'h0, 1'b0, 1'b1);
    run_txn(1'b1, 2'd2, 5'd1, 5'd3, 16'h0, 1'b0, 2, 16'h7E81, 1'b0, 1'b1);
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    report();
    $finish;
  end
endmodule